// File: doc/BRIEF.md
# SDRAM refresh and self-refresh manager

This block keeps an SDRAM refreshed and handles entry into and exit from its low-power self-refresh state. An interval timer produces one refresh demand per row slot. The slot length is the retention window divided by the row count, in clock cycles, and a parameter chooses the standard window or the shorter high-temperature window. Demands build up in a small pending counter. The manager takes the command bus from the command controller for each refresh. A PRECHARGE of all banks goes first, then the AUTO REFRESH, and then the bus is held quiet for the row cycle time. The bus is handed back afterwards.

A host level request asks for self-refresh. The manager precharges all banks and issues the self-refresh entry command with CKE low. It holds CKE low for at least the minimum active time and for as long as the request stays high. On exit it raises CKE and keeps the bus silent through the recovery window. The device cannot report which row it refreshed last, so the manager then issues one AUTO REFRESH per row, each one row cycle apart. After that burst it clears the backlog and restarts the interval timer.

Arbitration is by a grant level. While `ctl_grant` is high the controller owns the bus. The manager only takes the bus in a cycle that follows one in which the controller reported no burst in progress. A non-urgent action also waits for the controller's `ctl_yield` hint. When the backlog is full the refresh becomes urgent and ignores `ctl_yield`.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: Interval ticks occur every CLK_MHZ*W/REF_ROWS cycles, where W is HOT_WINDOW_US when HOT_GRADE=1 and STD_WINDOW_US otherwise. With the bus free and yielded, successive refreshes are exactly one interval apart.
- R2: Each tick raises the pending count by one, saturating at MAX_PEND. Each normal AUTO REFRESH lowers it by one, and a tick and a refresh in the same cycle leave it unchanged. `ref_req` is high when the count is non-zero and `ref_urgent` is high when the count equals MAX_PEND.
- R3: Every AUTO REFRESH that is not part of the exit burst, and every self-refresh entry, comes exactly T_RP cycles after a PRECHARGE-all, with only NOPs between them.
- R4: After a normal AUTO REFRESH the bus stays with the manager, carrying NOPs, for T_RC cycles. `ctl_grant` returns high exactly T_RC cycles after the refresh.
- R5: `ctl_grant` falls only after a cycle in which `ctl_burst` was low. With `ctl_yield` low and no urgent refresh, releasing `ctl_burst` does not start a takeover.
- R6: An urgent refresh is taken despite `ctl_yield` low. It appears as a PRECHARGE-all in the cycle after `ctl_burst` is seen low.
- R7: Self-refresh entry drives `cke` low together with the entry command. `cke` rises in cycle max(E+T_RAS, F+1), where E is the entry cycle and F is the first cycle after E with `sr_req` low.
- R8: From the cycle `cke` rises, the manager drives NOPs and keeps the grant low for max(T_XNOP, T_RC) cycles.
- R9: Then REF_ROWS AUTO REFRESH commands follow, T_RC cycles apart, and the grant returns T_RC cycles after the last one. Ticks from self-refresh entry up to the end of the burst are ignored, and the count is zero and the timer restarted when the burst ends.
- R10: Priority among pending actions is urgent refresh first, then self-refresh, then non-urgent refresh.
- R11: `ref_cmd` encodes 0 = NOP, 1 = PRECHARGE all banks, 2 = AUTO REFRESH, 3 = self-refresh entry. While `ctl_grant` is high, `ref_cmd` is 0 and `cke` is 1. After reset `ctl_grant`=1, `cke`=1, `ref_cmd`=0, `ref_req`=0 and `ref_urgent`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_burst | input | 1 | Command controller has a burst in progress |
| ctl_yield | input | 1 | Controller is willing to release the bus now |
| sr_req | input | 1 | Host level request to be in self-refresh |
| ctl_grant | output | 1 | Controller owns the command bus |
| ref_cmd | output | 2 | Command driven by the manager (encoding in R11) |
| cke | output | 1 | SDRAM clock enable |
| ref_req | output | 1 | Refresh backlog non-zero |
| ref_urgent | output | 1 | Refresh backlog at its limit |

## Verification
Two collisions matter. One is an interval tick landing in the same cycle as a normal AUTO REFRESH that consumes a pending demand. The other is an urgent refresh and a self-refresh request both waiting on the same release of the bus. The first is provoked by a sweep that holds `ctl_burst` high for every offset across one interval before releasing it. A backlog model in the bench recomputes tick times arithmetically and is compared with `ref_req` and `ref_urgent` in every cycle, so an extra or lost count shows as a mismatch. The second is provoked by raising `sr_req` while the backlog is full and the bus is blocked. It is judged by requiring that the first command after the precharge is an AUTO REFRESH and that self-refresh entry follows later.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_AREF = 2'd2,
    CMD_SREF = 2'd3
  } ref_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TRP, S_AREF, S_TRC,
    S_SRE, S_SRH, S_SRX, S_BAR, S_BRC
  } seq_state_e;

  function automatic int interval_cycles(input int clk_mhz, input int window_us,
                                         input int rows);
    int v;
    v = (clk_mhz * window_us) / rows;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int recovery_cycles(input int xnop, input int trc);
    return max2(xnop, trc);
  endfunction

  function automatic int width_for(input int top);
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int INTERVAL = 2078
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  import sdram_ref_pkg::*;

  localparam int TW = width_for(INTERVAL - 1);

  logic [TW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= TW'(INTERVAL - 1);
    end else if (restart || tick) begin
      cnt <= TW'(INTERVAL - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  generate
    if (INTERVAL > 1) begin : g_spacing
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      // R9
      restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ref_pending.sv
module ref_pending #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dec,
  input  logic freeze,
  input  logic clear,
  output logic pend_nz,
  output logic pend_full
);
  import sdram_ref_pkg::*;

  localparam int PW = width_for(MAX_PEND);

  logic [PW-1:0] cnt;
  logic          inc;

  assign inc       = tick && !freeze;
  assign pend_nz   = (cnt != '0);
  assign pend_full = (cnt == PW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      if (!pend_full) cnt <= cnt + 1'b1;
    end else if (!inc && dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  both_events_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clear) |=> $stable(cnt));
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> pend_nz);
  // R2
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && inc && !dec && !clear) |=> pend_full);
  // R9
  frozen_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !freeze);

endmodule

// File: rtl/ref_seq.sv
module ref_seq #(
  parameter int T_RP     = 3,
  parameter int T_RC     = 9,
  parameter int T_RAS    = 6,
  parameter int RECOV    = 9,
  parameter int REF_ROWS = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_burst,
  input  logic       ctl_yield,
  input  logic       sr_req,
  input  logic       pend_nz,
  input  logic       pend_full,
  output logic       ctl_grant,
  output logic [1:0] cmd,
  output logic       cke,
  output logic       ar_norm,
  output logic       freeze,
  output logic       restart
);
  import sdram_ref_pkg::*;

  localparam int CW = width_for(max2(max2(T_RP, T_RC), max2(T_RAS, RECOV)));
  localparam int RW = width_for(REF_ROWS - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rows_left;
  logic          pur_sr;
  logic          cnt_done;
  logic          ev_take;
  logic          ev_take_sr;

  assign cnt_done   = (cnt == '0);
  assign ev_take    = !ctl_burst && (pend_full || (ctl_yield && (sr_req || pend_nz)));
  assign ev_take_sr = !pend_full && sr_req;
  assign ctl_grant  = (state == S_IDLE);
  assign ar_norm    = (state == S_AREF);
  assign cke        = !((state == S_SRE) || (state == S_SRH));
  assign freeze     = (state == S_SRE) || (state == S_SRH) || (state == S_SRX) ||
                      (state == S_BAR) || (state == S_BRC);
  assign restart    = (state == S_BRC) && cnt_done && (rows_left == '0);

  always_comb begin
    case (state)
      S_PRE:         cmd = CMD_PALL;
      S_AREF, S_BAR: cmd = CMD_AREF;
      S_SRE:         cmd = CMD_SREF;
      default:       cmd = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rows_left <= '0;
      pur_sr    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (ev_take) begin
          state  <= S_PRE;
          pur_sr <= ev_take_sr;
        end
        S_PRE: begin
          state <= S_TRP;
          cnt   <= CW'(T_RP - 2);
        end
        S_TRP: if (cnt_done) state <= pur_sr ? S_SRE : S_AREF;
               else cnt <= cnt - 1'b1;
        S_AREF: begin
          state <= S_TRC;
          cnt   <= CW'(T_RC - 2);
        end
        S_TRC: if (cnt_done) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_SRE: begin
          state <= S_SRH;
          cnt   <= CW'(T_RAS - 2);
        end
        S_SRH: if (!cnt_done) cnt <= cnt - 1'b1;
               else if (!sr_req) begin
                 state <= S_SRX;
                 cnt   <= CW'(RECOV - 1);
               end
        S_SRX: if (cnt_done) begin
                 state     <= S_BAR;
                 rows_left <= RW'(REF_ROWS - 1);
               end else cnt <= cnt - 1'b1;
        S_BAR: begin
          state <= S_BRC;
          cnt   <= CW'(T_RC - 2);
        end
        S_BRC: if (!cnt_done) cnt <= cnt - 1'b1;
               else if (rows_left == '0) state <= S_IDLE;
               else begin
                 rows_left <= rows_left - 1'b1;
                 state     <= S_BAR;
               end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  grant_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_grant) |-> !$past(ctl_burst));
  // R3
  refresh_after_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_norm |-> ($past(state) == S_TRP));
  // R7
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_SRH) && sr_req) |=> !cke);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_grant |-> ((cmd == CMD_NOP) && cke));
  // R10
  urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_grant && !ctl_burst && pend_full) |=> ((state == S_PRE) && !pur_sr));

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr #(
  parameter int CLK_MHZ       = 133,
  parameter int STD_WINDOW_US = 64000,
  parameter int HOT_WINDOW_US = 16000,
  parameter bit HOT_GRADE     = 1'b0,
  parameter int REF_ROWS      = 4096,
  parameter int MAX_PEND      = 8,
  parameter int T_RP          = 3,
  parameter int T_RC          = 9,
  parameter int T_RAS         = 6,
  parameter int T_XNOP        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_burst,
  input  logic       ctl_yield,
  input  logic       sr_req,
  output logic       ctl_grant,
  output logic [1:0] ref_cmd,
  output logic       cke,
  output logic       ref_req,
  output logic       ref_urgent
);
  import sdram_ref_pkg::*;

  localparam int WINDOW_US = HOT_GRADE ? HOT_WINDOW_US : STD_WINDOW_US;
  localparam int INTERVAL  = interval_cycles(CLK_MHZ, WINDOW_US, REF_ROWS);
  localparam int RECOV     = recovery_cycles(T_XNOP, T_RC);

  logic tick;
  logic restart;
  logic ar_norm;
  logic freeze;
  logic pend_nz;
  logic pend_full;

  ref_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  ref_pending #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(ar_norm), .freeze(freeze),
    .clear(restart), .pend_nz(pend_nz), .pend_full(pend_full)
  );

  ref_seq #(
    .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS), .RECOV(RECOV), .REF_ROWS(REF_ROWS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_burst(ctl_burst), .ctl_yield(ctl_yield),
    .sr_req(sr_req), .pend_nz(pend_nz), .pend_full(pend_full),
    .ctl_grant(ctl_grant), .cmd(ref_cmd), .cke(cke), .ar_norm(ar_norm),
    .freeze(freeze), .restart(restart)
  );

  assign ref_req    = pend_nz;
  assign ref_urgent = pend_full;

endmodule

// File: tb/sdram_refresh_mgr_test.sv
module sdram_refresh_mgr_test;

  localparam int CLK_MHZ = 1;
  localparam int STDW    = 256;
  localparam int HOTW    = 64;
  localparam int ROWS    = 8;
  localparam int MAXP    = 3;
  localparam int TRP     = 2;
  localparam int TRC     = 4;
  localparam int TRAS    = 6;
  localparam int TXN     = 2;
  localparam int INTV     = (CLK_MHZ * STDW) / ROWS;
  localparam int INTV_HOT = (CLK_MHZ * HOTW) / ROWS;
  localparam int RECOV    = (TXN > TRC) ? TXN : TRC;
  localparam logic [1:0] C_NOP = 2'd0, C_PALL = 2'd1, C_AREF = 2'd2, C_SREF = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst = 1'b0;
  logic yield = 1'b1;
  logic sr = 1'b0;
  logic grant, cke, req, urg;
  logic [1:0] cmd;
  logic hot_grant, hot_cke, hot_req, hot_urg;
  logic [1:0] hot_cmd;

  always #4 clk = ~clk;

  sdram_refresh_mgr #(
    .CLK_MHZ(CLK_MHZ), .STD_WINDOW_US(STDW), .HOT_WINDOW_US(HOTW), .HOT_GRADE(1'b0),
    .REF_ROWS(ROWS), .MAX_PEND(MAXP), .T_RP(TRP), .T_RC(TRC), .T_RAS(TRAS), .T_XNOP(TXN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ctl_burst(burst), .ctl_yield(yield), .sr_req(sr),
    .ctl_grant(grant), .ref_cmd(cmd), .cke(cke), .ref_req(req), .ref_urgent(urg)
  );

  sdram_refresh_mgr #(
    .CLK_MHZ(CLK_MHZ), .STD_WINDOW_US(STDW), .HOT_WINDOW_US(HOTW), .HOT_GRADE(1'b1),
    .REF_ROWS(ROWS), .MAX_PEND(MAXP), .T_RP(TRP), .T_RC(TRC), .T_RAS(TRAS), .T_XNOP(TXN)
  ) uut_hot (
    .clk(clk), .rst_n(rst_n), .ctl_burst(burst), .ctl_yield(yield), .sr_req(sr),
    .ctl_grant(hot_grant), .ref_cmd(hot_cmd), .cke(hot_cke), .ref_req(hot_req),
    .ref_urgent(hot_urg)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  // monitor state
  int n = 0;
  int model = 0;
  bit frozen = 0;
  int phase = 0;
  int pre_n = -1;
  int ret_n = -1;
  bit ret_burst = 0;
  int ar_n = -1;
  int low_start = -1;
  int free_n = -1;
  int burst_left = 0;
  int burst_next = -1;
  int restart_n = -1;
  int last_norm = -1;
  int hot_last = -1;
  int norm_count = 0;
  bit phase_a = 1;
  logic cke_prev = 1'b1, grant_prev = 1'b1, burst_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit due_pre, due_burst, norm_ar, tk;
      due_pre   = (pre_n >= 0) && (n == pre_n + TRP);
      due_burst = (burst_left > 0) && (n == burst_next);
      norm_ar   = (cmd == C_AREF) && due_pre;

      // R11 controller-owned bus is quiet
      if (grant) chk(cmd == C_NOP && cke, "R11 quiet while granted", cmd, 0);
      // R2 backlog flags against model
      chk(req == (model != 0), "R2 ref_req", req, model != 0);
      chk(urg == (model == MAXP), "R2 ref_urgent", urg, model == MAXP);
      // R5 takeover only after burst-free cycle
      if (grant_prev && !grant) chk(!burst_prev, "R5 grant taken in burst", burst_prev, 0);

      // R3 placement of refresh and entry commands
      if (cmd == C_AREF || cmd == C_SREF)
        chk(due_pre || (cmd == C_AREF && due_burst), "R3 command placement", cmd, 0);
      if (pre_n >= 0 && n > pre_n && n < pre_n + TRP)
        chk(cmd == C_NOP, "R3 gap after precharge", cmd, C_NOP);
      if (due_pre) begin
        chk(cmd == C_AREF || cmd == C_SREF, "R3 command after precharge", cmd, C_AREF);
        pre_n = -1;
      end
      if (cmd == C_PALL) pre_n = n;

      // R4 and R9 bus release
      if (ret_n >= 0) begin
        if (n == ret_n) begin
          chk(grant, ret_burst ? "R9 release after burst" : "R4 release after refresh", grant, 1);
          ret_n = -1;
        end else if (n > ar_n) begin
          chk(!grant && cmd == C_NOP, ret_burst ? "R9 quiet gap" : "R4 quiet gap", cmd, 0);
        end
      end
      if (norm_ar) begin
        ret_n = n + TRC; ret_burst = 0; ar_n = n; norm_count++;
        if (phase_a && last_norm >= 0) chk(n - last_norm == INTV, "R1 refresh spacing", n - last_norm, INTV);
        last_norm = n;
      end

      // R7 self-refresh entry and hold
      if (cmd == C_SREF) begin
        chk(!cke, "R7 cke low at entry", cke, 0);
        frozen = 1; low_start = n; free_n = -1;
      end
      if (!cke && low_start >= 0 && n > low_start && !sr && free_n < 0) free_n = n;
      if (cke && !cke_prev && low_start >= 0) begin
        int exp_rise;
        exp_rise = low_start + TRAS;
        if (free_n + 1 > exp_rise) exp_rise = free_n + 1;
        chk(n == exp_rise, "R7 cke rise cycle", n, exp_rise);
        burst_next = n + RECOV; burst_left = ROWS; low_start = -1;
      end
      // R8 recovery window
      if (burst_left == ROWS && n < burst_next)
        chk(cmd == C_NOP && !grant, "R8 recovery nops", cmd, C_NOP);
      // R9 exit burst
      if (due_burst) begin
        chk(cmd == C_AREF, "R9 burst refresh", cmd, C_AREF);
        burst_left--; ar_n = n;
        burst_next = n + TRC;
        if (burst_left == 0) begin
          ret_n = n + TRC; ret_burst = 1; restart_n = n + TRC - 1;
        end
      end

      // R1 high-temperature instance spacing
      if (hot_cmd == C_AREF) begin
        if (phase_a && hot_last >= 0) chk(n - hot_last == INTV_HOT, "R1 hot grade spacing", n - hot_last, INTV_HOT);
        hot_last = n;
      end

      // backlog model update for next cycle
      tk = (n >= phase) && (((n - phase) % INTV) == INTV - 1);
      if (n == restart_n) begin
        model = 0; frozen = 0; phase = n + 1; restart_n = -1;
      end else if (!frozen) begin
        if (tk && !norm_ar) model = (model == MAXP) ? MAXP : model + 1;
        else if (!tk && norm_ar) model = model - 1;
      end

      cke_prev = cke; grant_prev = grant; burst_prev = burst;
      n++;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(grant, "R11 reset grant", grant, 1);
    chk(cke, "R11 reset cke", cke, 1);
    chk(cmd == C_NOP, "R11 reset command", cmd, 0);
    chk(!req && !urg, "R11 reset backlog flags", {req, urg}, 0);

    // free bus: periodic refresh
    step(5 * INTV + 10);
    phase_a = 0;
    chk(norm_count >= 4, "R1 refreshes seen", norm_count, 4);

    // R6 urgent refresh with yield low
    yield = 1'b0;
    for (int i = 0; i < 5 * INTV && !urg; i++) step(1);
    chk(urg, "R6 backlog reaches limit", urg, 1);
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 20 && !seen; i++) begin
        if (cmd == C_AREF) seen = 1;
        step(1);
      end
      chk(seen, "R6 urgent refresh while not yielded", seen, 1);
    end
    step(2 * INTV);

    // burst hold sweep over every offset of one interval
    for (int off = 0; off < INTV; off++) begin
      bit was_urg;
      burst = 1'b1;
      step(INTV + off);
      was_urg = urg;
      burst = 1'b0;
      step(1);
      if (was_urg) chk(cmd == C_PALL, "R6 precharge after burst release", cmd, C_PALL);
      else chk(cmd == C_NOP, "R5 no takeover without yield", cmd, C_NOP);
      step(1);
    end

    // long self-refresh
    yield = 1'b1;
    step(INTV);
    sr = 1'b1;
    for (int i = 0; i < 100 && cke; i++) step(1);
    chk(!cke, "R7 self-refresh entered", cke, 0);
    step(10);
    sr = 1'b0;
    step(RECOV + ROWS * TRC + 4);
    for (int i = 0; i < 50 && !grant; i++) step(1);
    chk(grant && !req, "R9 backlog cleared after exit", req, 0);

    // minimum-length self-refresh
    sr = 1'b1;
    for (int i = 0; i < 100 && cmd != C_SREF; i++) step(1);
    sr = 1'b0;
    step(TRAS + RECOV + ROWS * TRC + 6);

    // R10 urgent refresh against self-refresh request
    yield = 1'b0;
    for (int i = 0; i < 6 * INTV && !urg; i++) step(1);
    burst = 1'b1;
    sr = 1'b1;
    yield = 1'b1;
    step(3 * TRC);
    burst = 1'b0;
    begin
      logic [1:0] first;
      bit got_sr;
      first = C_NOP;
      for (int i = 0; i < 30 && first == C_NOP; i++) begin
        if (cmd == C_AREF || cmd == C_SREF) first = cmd;
        step(1);
      end
      chk(first == C_AREF, "R10 urgent refresh before self-refresh", first, C_AREF);
      got_sr = 0;
      for (int i = 0; i < 40 && !got_sr; i++) begin
        if (cmd == C_SREF) got_sr = 1;
        step(1);
      end
      chk(got_sr, "R10 self-refresh follows", got_sr, 1);
    end
    sr = 1'b0;
    step(TRAS + RECOV + ROWS * TRC + 20);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule